// File: doc/BRIEF.md
# Adaptive Proportion Health Monitor

This block watches a stream of noise-source samples for a large loss of entropy. The stream is split into windows of a fixed number of samples. The first sample of each window is stored as a reference. Every later sample in the same window is compared with that reference, and each match is counted. If the count of matches reaches a programmable threshold, the block sets a sticky failure flag. When the interrupt enable is high, it also raises an interrupt.

The sample source pulses `smp_vld` once per sample. In the intended system that happens about once every 84 clock cycles. The logic does not depend on that spacing. The threshold comes from a configuration register held outside the block. A read of the status register elsewhere produces a one-cycle `rd_clr` strobe, which clears the flag.

Top module: `ap_health_mon`

## Requirements
- R1: After reset, `ap_flag` and `irq` are 0, and the first sample accepted after reset is treated as sample 0 of a window.
- R2: Sample 0 of every window is loaded as the reference and is never counted as a match.
- R3: A later sample in the same window increments the match count only when its data equals the reference. A sample whose data differs leaves the count unchanged.
- R4: With `thr` ≥ 1, the sample that brings the match count up to `thr` sets `ap_flag`. The flag is visible on the clock edge that accepts that sample.
- R5: The match count saturates at `thr` and does not wrap. Matches after saturation in the same window do not set the flag again, even if the flag was cleared in the meantime.
- R6: A window holds exactly `WIN_LEN` samples. After the last one, the count restarts and the next sample becomes the new reference.
- R7: A `thr` of 0 never sets `ap_flag`.
- R8: `ap_flag` stays at 1 until a cycle with `rd_clr` = 1 clears it. When a setting sample and `rd_clr` arrive in the same cycle, the flag ends up at 1.
- R9: `irq` equals `ap_flag` AND `irq_en`, with no added delay.
- R10: Cycles with `smp_vld` = 0 change neither the window position, nor the reference, nor the count, nor the flag, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | DATA_W | Sample value |
| thr | input | $clog2(WIN_LEN) | Match threshold; 0 disables detection |
| rd_clr | input | 1 | Status-read strobe that clears the flag |
| irq_en | input | 1 | Interrupt enable |
| ap_flag | output | 1 | Sticky entropy-loss flag |
| irq | output | 1 | Interrupt request |

## Verification
The flag is one register stage after its cause. A sample or clear strobe that is driven before a rising edge shows its effect on `ap_flag` right after that edge. The bench therefore drives each stimulus at a falling edge and samples the outputs at the next falling edge. `irq` is combinational from the flag and `irq_en`, so the bench checks it shortly after changing `irq_en`, with no clock edge in between. Idle cycles are checked by showing that later samples keep the same window position the bench's arithmetic expects.

// File: rtl/ap_health_mon.sv
module ap_health_mon #(
  parameter int DATA_W  = 32,
  parameter int WIN_LEN = 512,
  localparam int IDX_W  = $clog2(WIN_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [IDX_W-1:0]  thr,
  input  logic              rd_clr,
  input  logic              irq_en,
  output logic              ap_flag,
  output logic              irq
);

  logic [IDX_W-1:0]  idx, cnt;
  logic [DATA_W-1:0] ref_q;

  wire first = (idx == '0);
  wire last  = (idx == IDX_W'(WIN_LEN - 1));
  wire match = smp_vld && !first && (smp_data == ref_q) && (cnt < thr);
  wire hit   = match && ((cnt + IDX_W'(1)) == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      cnt   <= '0;
      ref_q <= '0;
    end else if (smp_vld) begin
      idx <= last ? '0 : idx + IDX_W'(1);
      if (first) begin
        ref_q <= smp_data;
        cnt   <= '0;
      end else if (match) begin
        cnt <= cnt + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ap_flag <= 1'b0;
    else if (hit)    ap_flag <= 1'b1;
    else if (rd_clr) ap_flag <= 1'b0;
  end

  assign irq = ap_flag & irq_en;

  assert_ref_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && first |=> ref_q == $past(smp_data) && cnt == '0);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !first && cnt >= thr |=> cnt == $past(cnt));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && last |=> idx == '0);
  assert_zero_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_flag && thr == '0 |=> !ap_flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ap_flag && !rd_clr |=> ap_flag);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(idx) && $stable(cnt) && $stable(ref_q));

endmodule

// File: tb/tb_ap_health_mon.sv
module tb_ap_health_mon;
  localparam int DW = 4, WL = 8, IW = 3;

  logic clk = 0, rst_n = 0, smp_vld = 0, rd_clr = 0, irq_en = 0;
  logic [DW-1:0] smp_data = '0;
  logic [IW-1:0] thr = '0;
  logic ap_flag, irq;

  int checks = 0, errors = 0;
  int m_idx = 0, m_cnt = 0;
  logic [DW-1:0] m_ref = '0;
  logic m_flag = 0;

  ap_health_mon #(.DATA_W(DW), .WIN_LEN(WL)) dut (
    .clk, .rst_n, .smp_vld, .smp_data, .thr, .rd_clr, .irq_en, .ap_flag, .irq);

  always #4 clk = ~clk;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    chk(req, ap_flag, m_flag);
    chk("R9", irq, m_flag & irq_en);
  endtask

  task automatic sample(logic [DW-1:0] d, logic clr);
    logic hit = 0;
    @(negedge clk);
    smp_vld = 1; smp_data = d; rd_clr = clr;
    if (m_idx == 0) begin m_ref = d; m_cnt = 0; end       // R2
    else if (d == m_ref && m_cnt < int'(thr)) begin        // R3, R5
      m_cnt++;
      hit = (m_cnt == int'(thr));                          // R4, R7
    end
    m_idx = (m_idx + 1) % WL;                              // R6
    m_flag = hit ? 1'b1 : (clr ? 1'b0 : m_flag);           // R8
    @(negedge clk);
    smp_vld = 0; rd_clr = 0;
    #1 check_outs(hit ? "R4" : "R3");
  endtask

  task automatic idle(logic [DW-1:0] junk);
    @(negedge clk);
    smp_data = junk;
    @(negedge clk);
    #1 check_outs("R10");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1", ap_flag, 0); chk("R1", irq, 0);
    rst_n = 1;
    for (int t = 0; t < 8; t++) begin
      thr = IW'(t);
      for (int w = 0; w < 3; w++) begin
        logic [DW-1:0] base = DW'(t) ^ DW'(w);
        irq_en = w[0];
        for (int k = 0; k < WL; k++) begin
          logic [DW-1:0] d;
          case (w)
            0: d = base;
            1: d = (k % 2 == 0) ? base : ~base;
            default: d = (k % 3 == 0) ? base : base + 1'b1;
          endcase
          if (k == 2) idle(~base);
          sample(d, (k == 4 && w != 2));
        end
        if (m_flag) begin
          @(negedge clk); irq_en = 1; #1 chk("R9", irq, 1);
          irq_en = 0; #1 chk("R9", irq, 0);
          @(negedge clk); rd_clr = 1; m_flag = 0;
          @(negedge clk); rd_clr = 0; #1 chk("R8", ap_flag, 0);
        end
      end
    end
    // thr=1: set and clear in the same cycle, set wins (R8); clear then saturated matches (R5)
    thr = 3'd1; irq_en = 1;
    sample(4'd9, 0);
    sample(4'd9, 1);
    chk("R8", ap_flag, 1);
    sample(4'd2, 1);
    chk("R8", ap_flag, 0);
    sample(4'd9, 0);
    chk("R5", ap_flag, 0);
    for (int k = 4; k < WL; k++) sample(4'd9, 0);
    sample(4'd7, 0);                                       // R6 new reference
    sample(4'd7, 0);
    chk("R6", ap_flag, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule